// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits beside an SDRAM device interface and watches the control and address lines exactly as the memory would see them. On each rising clock edge it turns the strobe pattern into a single command. It extracts the row or column address, using the column width set by the device organisation. It also keeps a record of which of the four banks are open and which row each one holds.

Address bit 10 has two meanings. On a read or write it schedules an automatic close of the addressed bank. That close happens a fixed, parameterised number of cycles later. On a precharge, bit 10 widens the close from the selected bank to every bank. The block also flags two kinds of misuse. The first is an access that does not fit the current bank state. The second is a command to a bank that is still waiting on a scheduled close. Monitors and protocol checkers can take the decoded command, the flags and the per-bank state straight from the outputs.

All outputs are registered. Every result reflects the inputs sampled at the previous rising edge.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After each rising edge, `cmd_o` holds at most one set bit, which reflects the inputs sampled at that edge. With {ras_n,cas_n,we_n} given as levels, the bit indices are: 0 no-op (H,H,H), 1 activate (L,H,H), 2 read (H,L,H), 3 write (H,L,L), 4 precharge (L,H,L), 5 auto refresh (L,L,H), 6 load mode (L,L,L), 7 burst stop (H,H,L).
- R2: When chip select is high at an edge, `cmd_o` is zero and bank state is unchanged. A bank close that is already scheduled still completes on time.
- R3: When clock enable is low at an edge, `pdown_o` is 1, `cmd_o` is zero and no command takes effect. When clock enable is high, `pdown_o` is 0 and decoding resumes.
- R4: A legal activate marks bank `ba_i` open with row `addr_i[11:0]`. It also sets `addr_o` to that row and `bank_o` to `ba_i`.
- R5: On a read or write, `addr_o` is the column, zero-extended. For DQ_WIDTH=4 it is {A11,A9..A0}, for 8 it is A9..A0, and for 16 it is A8..A0.
- R6: A legal read or write with A10 high sets `auto_pre_o`. The bank then closes BURST_LEN edges after the command edge. With A10 low, `auto_pre_o` is 0 and the bank stays open.
- R7: A legal precharge with A10 high closes every bank and sets `pre_mask_o` to 4'b1111. With A10 low it closes only bank `ba_i`, and `pre_mask_o` has just bit `ba_i` set. Otherwise `pre_mask_o` is zero.
- R8: A read or write to a closed bank, or an activate to an open bank, sets `illegal_o` for one cycle and leaves all bank state unchanged.
- R9: An activate, read, write or precharge whose target includes a bank with a scheduled close sets `ap_err_o`. Such a command has no effect on bank state, and `illegal_o` stays 0.
- R10: No-op, burst stop, auto refresh and load mode change no bank state, and they leave `addr_o` and `bank_o` unchanged.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low suspends decoding |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 12 | Row / column address, bit 10 is the precharge qualifier |
| ba_i | input | 2 | Bank select |
| cmd_o | output | 8 | One-hot decoded command |
| addr_o | output | 12 | Last row or column address |
| bank_o | output | 2 | Last targeted bank |
| auto_pre_o | output | 1 | Read/write with scheduled close accepted |
| pre_mask_o | output | 4 | Banks closed by a precharge command |
| pdown_o | output | 1 | Clock enable was low |
| bank_open_o | output | 4 | Per-bank open flag |
| open_row_o | output | 48 | Per-bank open row, bank n at bits 12n+11..12n |
| illegal_o | output | 1 | Access inconsistent with bank state |
| ap_err_o | output | 1 | Command hit a bank with a pending close |

## Verification
A corrupted open flag shows up in two ways. It is visible on `bank_open_o` one cycle after the edge that caused it. It also produces a false or missing `illegal_o` on the next access to that bank. A countdown that is off by one moves the falling edge of the open flag by a cycle relative to the read or write that scheduled it. A pending flag that lingers raises `ap_err_o` on a later command. Because every output is compared on every cycle, a fault appears at the first edge where state and stimulus interact.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;
  localparam int CMD_N   = 8;
  localparam int C_NOP   = 0;
  localparam int C_ACT   = 1;
  localparam int C_RD    = 2;
  localparam int C_WR    = 3;
  localparam int C_PRE   = 4;
  localparam int C_REF   = 5;
  localparam int C_MRS   = 6;
  localparam int C_BST   = 7;
  localparam int ADDR_W  = 12;
  localparam int BA_W    = 2;
  localparam int BANKS   = 1 << BA_W;
  localparam int AP_BIT  = 10;

  typedef logic [CMD_N-1:0] cmd_vec_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_trk_pkg::*;
(
  input  logic     cke_i,
  input  logic     cs_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     we_ni,
  output cmd_vec_t cmd_o
);
  always_comb begin
    cmd_o = '0;
    if (cke_i && !cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o[C_NOP] = 1'b1;
        3'b011:  cmd_o[C_ACT] = 1'b1;
        3'b101:  cmd_o[C_RD]  = 1'b1;
        3'b100:  cmd_o[C_WR]  = 1'b1;
        3'b010:  cmd_o[C_PRE] = 1'b1;
        3'b001:  cmd_o[C_REF] = 1'b1;
        3'b000:  cmd_o[C_MRS] = 1'b1;
        default: cmd_o[C_BST] = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sdram_col_sel.sv
module sdram_col_sel
  import sdram_trk_pkg::*;
#(
  parameter int DQ_WIDTH = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] col_o,
  output logic              ap_o
);
  localparam int COL_W = (DQ_WIDTH == 16) ? 9 : (DQ_WIDTH == 8) ? 10 : 11;

  logic [COL_W-1:0] col;

  generate
    if (DQ_WIDTH == 16) begin : g_x16
      assign col = addr_i[8:0];
    end else if (DQ_WIDTH == 8) begin : g_x8
      assign col = addr_i[9:0];
    end else begin : g_x4
      assign col = {addr_i[11], addr_i[9:0]};
    end
  endgenerate

  assign col_o = ADDR_W'(col);
  assign ap_o  = addr_i[AP_BIT];
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
  parameter int ROW_W     = 12,
  parameter int BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic             sched_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             pend_o
);
  localparam int CNT_W = (BURST_LEN < 2) ? 1 : $clog2(BURST_LEN + 1);

  logic             open_q, pend_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      row_q  <= '0;
      cnt_q  <= '0;
    end else if (pend_q && cnt_q == '0) begin
      // scheduled close fires
      open_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (pend_q) cnt_q <= cnt_q - 1'b1;
      if (open_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
      end
      if (close_i) open_q <= 1'b0;
      if (sched_i) begin
        pend_q <= 1'b1;
        cnt_q  <= CNT_W'(BURST_LEN - 1);
      end
    end
  end

  assign open_o = open_q;
  assign row_o  = row_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int DQ_WIDTH  = 4,
  parameter int BURST_LEN = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cke_i,
  input  logic               cs_ni,
  input  logic               ras_ni,
  input  logic               cas_ni,
  input  logic               we_ni,
  input  logic [11:0]        addr_i,
  input  logic [1:0]         ba_i,
  output logic [7:0]         cmd_o,
  output logic [11:0]        addr_o,
  output logic [1:0]         bank_o,
  output logic               auto_pre_o,
  output logic [3:0]         pre_mask_o,
  output logic               pdown_o,
  output logic [3:0]         bank_open_o,
  output logic [47:0]        open_row_o,
  output logic               illegal_o,
  output logic               ap_err_o
);
  cmd_vec_t          cmd_now;
  logic [ADDR_W-1:0] col;
  logic              ap_bit;
  logic [BANKS-1:0]  open_v, pend_v, tgt, set_open, set_close, set_sched;
  logic              is_act, is_rw, is_pre, bank_cmd, conflict, illegal, ok;

  sdram_cmd_decode u_dec (
    .cke_i (cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni), .cas_ni(cas_ni),
    .we_ni (we_ni), .cmd_o(cmd_now)
  );

  sdram_col_sel #(.DQ_WIDTH(DQ_WIDTH)) u_col (
    .addr_i(addr_i), .col_o(col), .ap_o(ap_bit)
  );

  assign is_act   = cmd_now[C_ACT];
  assign is_rw    = cmd_now[C_RD] | cmd_now[C_WR];
  assign is_pre   = cmd_now[C_PRE];
  assign bank_cmd = is_act | is_rw | is_pre;

  always_comb begin
    tgt = '0;
    if (is_pre && ap_bit) tgt = '1;
    else if (bank_cmd)    tgt[ba_i] = 1'b1;
  end

  assign conflict  = bank_cmd && |(tgt & pend_v);
  assign illegal   = !conflict && ((is_act && open_v[ba_i]) || (is_rw && !open_v[ba_i]));
  assign ok        = bank_cmd && !conflict && !illegal;
  assign set_open  = (ok && is_act) ? tgt : '0;
  assign set_close = (ok && is_pre) ? tgt : '0;
  assign set_sched = (ok && is_rw && ap_bit) ? tgt : '0;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sdram_bank_slot #(.ROW_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .open_i (set_open[b]),
      .close_i(set_close[b]),
      .sched_i(set_sched[b]),
      .row_i  (addr_i),
      .open_o (open_v[b]),
      .row_o  (open_row_o[b*ADDR_W +: ADDR_W]),
      .pend_o (pend_v[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      addr_o     <= '0;
      bank_o     <= '0;
      auto_pre_o <= 1'b0;
      pre_mask_o <= '0;
      pdown_o    <= 1'b0;
      illegal_o  <= 1'b0;
      ap_err_o   <= 1'b0;
    end else begin
      cmd_o      <= cmd_now;
      pdown_o    <= !cke_i;
      illegal_o  <= illegal;
      ap_err_o   <= conflict;
      pre_mask_o <= set_close;
      auto_pre_o <= ok && is_rw && ap_bit;
      if (is_act)   addr_o <= addr_i;
      if (is_rw)    addr_o <= col;
      if (bank_cmd) bank_o <= ba_i;
    end
  end

  assign bank_open_o = open_v;
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cke_i,
  input logic        cs_ni,
  input logic [7:0]  cmd_o,
  input logic [11:0] addr_o,
  input logic [1:0]  bank_o,
  input logic [3:0]  pre_mask_o,
  input logic        pdown_o,
  input logic [3:0]  bank_open_o,
  input logic [47:0] open_row_o,
  input logic        illegal_o,
  input logic        ap_err_o
);
  a_r1_cmd_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o));

  a_r2_deselect_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (cmd_o == '0));

  a_r3_pdown_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |=> (pdown_o && cmd_o == '0));

  a_r4_act_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[1] && !illegal_o && !ap_err_o) |->
      (bank_open_o[bank_o] && open_row_o[bank_o*12 +: 12] == addr_o));

  a_r7_pre_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pre_mask_o) |-> ((bank_open_o & pre_mask_o) == 4'b0));

  a_r8_illegal_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (cmd_o[1] | cmd_o[2] | cmd_o[3]));

  a_r9_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_err_o |-> (!illegal_o && pre_mask_o == 4'b0 && (cmd_o[4:1] != 4'b0)));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
  .cmd_o(cmd_o), .addr_o(addr_o), .bank_o(bank_o), .pre_mask_o(pre_mask_o),
  .pdown_o(pdown_o), .bank_open_o(bank_open_o), .open_row_o(open_row_o),
  .illegal_o(illegal_o), .ap_err_o(ap_err_o)
);

// File: tb/test_sdram_cmd_tracker.sv
module test_sdram_cmd_tracker;
  localparam int BL = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  ba = '0;
  logic [7:0]  cmd_o;
  logic [11:0] addr_o;
  logic [1:0]  bank_o;
  logic        auto_pre_o, pdown_o, illegal_o, ap_err_o;
  logic [3:0]  pre_mask_o, bank_open_o;
  logic [47:0] open_row_o;

  int checks = 0, errors = 0;

  typedef struct {
    string       tag;
    logic [7:0]  cmd;
    logic [11:0] addr;
    logic [1:0]  bank;
    logic        ap;
    logic [3:0]  mask;
    logic        pdn;
    logic [3:0]  open;
    logic [47:0] rows;
    logic        ill;
    logic        err;
  } exp_t;

  exp_t sb[$];

  // bench model state
  logic [3:0]  m_open = '0, m_pend = '0;
  logic [47:0] m_rows = '0;
  int          m_cnt[4] = '{0, 0, 0, 0};
  logic [11:0] m_addr = '0;
  logic [1:0]  m_bank = '0;

  always #2ns clk = ~clk;

  sdram_cmd_tracker #(.DQ_WIDTH(4), .BURST_LEN(BL)) i_sdram_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .addr_i(addr), .ba_i(ba), .cmd_o(cmd_o),
    .addr_o(addr_o), .bank_o(bank_o), .auto_pre_o(auto_pre_o),
    .pre_mask_o(pre_mask_o), .pdown_o(pdown_o), .bank_open_o(bank_open_o),
    .open_row_o(open_row_o), .illegal_o(illegal_o), .ap_err_o(ap_err_o)
  );

  task automatic issue(input string tag, input logic k, input logic c,
                       input logic [2:0] rcw, input logic [11:0] a,
                       input logic [1:0] b);
    exp_t e;
    logic [7:0] cv = '0;
    logic [3:0] tg = '0;
    logic act, rw, pre, bc, conf, ill, ok;
    @(negedge clk);
    cke = k; cs_n = c; {ras_n, cas_n, we_n} = rcw; addr = a; ba = b;
    if (k && !c) begin
      case (rcw)
        3'b111: cv[0] = 1'b1;
        3'b011: cv[1] = 1'b1;
        3'b101: cv[2] = 1'b1;
        3'b100: cv[3] = 1'b1;
        3'b010: cv[4] = 1'b1;
        3'b001: cv[5] = 1'b1;
        3'b000: cv[6] = 1'b1;
        default: cv[7] = 1'b1;
      endcase
    end
    act = cv[1]; rw = cv[2] | cv[3]; pre = cv[4]; bc = act | rw | pre;
    if (pre && a[10]) tg = 4'hF; else if (bc) tg[b] = 1'b1;
    conf = bc && ((tg & m_pend) != 0);
    ill  = !conf && ((act && m_open[b]) || (rw && !m_open[b]));
    ok   = bc && !conf && !ill;
    e.tag = tag; e.cmd = cv; e.pdn = !k; e.ill = ill; e.err = conf;
    e.ap = ok && rw && a[10];
    e.mask = (ok && pre) ? tg : 4'h0;
    if (act) m_addr = a;
    if (rw) m_addr = {1'b0, a[11], a[9:0]};
    if (bc) m_bank = b;
    for (int i = 0; i < 4; i++) begin
      if (m_pend[i] && m_cnt[i] == 0) begin
        m_open[i] = 1'b0; m_pend[i] = 1'b0;
      end else begin
        if (m_pend[i]) m_cnt[i]--;
        if (ok && tg[i]) begin
          if (act) begin m_open[i] = 1'b1; m_rows[i*12 +: 12] = a; end
          if (pre) m_open[i] = 1'b0;
          if (rw && a[10]) begin m_pend[i] = 1'b1; m_cnt[i] = BL - 1; end
        end
      end
    end
    e.addr = m_addr; e.bank = m_bank; e.open = m_open; e.rows = m_rows;
    sb.push_back(e);
  endtask

  task automatic cmd(input string tag, input logic [2:0] rcw,
                     input logic [11:0] a, input logic [1:0] b);
    issue(tag, 1'b1, 1'b0, rcw, a, b);
  endtask

  // monitor
  always @(posedge clk) begin
    #1ns;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (cmd_o !== e.cmd || addr_o !== e.addr || bank_o !== e.bank ||
          auto_pre_o !== e.ap || pre_mask_o !== e.mask || pdown_o !== e.pdn ||
          bank_open_o !== e.open || open_row_o !== e.rows ||
          illegal_o !== e.ill || ap_err_o !== e.err) begin
        errors++;
        $display("FAIL %s: got cmd=%h addr=%h bank=%0d ap=%b mask=%b pdn=%b open=%b rows=%h ill=%b err=%b exp cmd=%h addr=%h bank=%0d ap=%b mask=%b pdn=%b open=%b rows=%h ill=%b err=%b",
          e.tag, cmd_o, addr_o, bank_o, auto_pre_o, pre_mask_o, pdown_o, bank_open_o,
          open_row_o, illegal_o, ap_err_o, e.cmd, e.addr, e.bank, e.ap, e.mask,
          e.pdn, e.open, e.rows, e.ill, e.err);
      end
    end
  end

  initial begin
    #(200000 * 4ns);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({cmd_o, addr_o, bank_o, auto_pre_o, pre_mask_o, pdown_o, bank_open_o,
         open_row_o, illegal_o, ap_err_o} !== '0) begin
      errors++;
      $display("FAIL R11 reset: got cmd=%h open=%b exp all zero", cmd_o, bank_open_o);
    end
    rst_n = 1'b1;
    cmd("R1 nop",           3'b111, 12'h000, 2'd0);
    cmd("R4 act b1",        3'b011, 12'hABC, 2'd1);
    cmd("R8 act open b1",   3'b011, 12'h111, 2'd1);
    cmd("R8 rd closed b0",  3'b101, 12'h005, 2'd0);
    cmd("R5 rd b1 col",     3'b101, 12'h805, 2'd1);
    cmd("R5 wr b1 col",     3'b100, 12'h3FF, 2'd1);
    cmd("R4 act b2",        3'b011, 12'h123, 2'd2);
    cmd("R6 wr b2 ap",      3'b100, 12'h4FF, 2'd2);
    cmd("R9 rd b2 pending", 3'b101, 12'h001, 2'd2);
    cmd("R9 pre all pend",  3'b010, 12'h400, 2'd0);
    cmd("R6 nop wait",      3'b111, 12'h000, 2'd0);
    cmd("R6 b2 closed",     3'b111, 12'h000, 2'd0);
    cmd("R6 after close",   3'b111, 12'h000, 2'd0);
    issue("R2 deselect act", 1'b1, 1'b1, 3'b011, 12'h777, 2'd3);
    issue("R3 cke low",      1'b0, 1'b0, 3'b011, 12'h777, 2'd3);
    issue("R3 cke low pre",  1'b0, 1'b0, 3'b010, 12'h400, 2'd0);
    cmd("R3 resume",        3'b111, 12'h000, 2'd0);
    cmd("R10 burst stop",   3'b110, 12'hFFF, 2'd3);
    cmd("R10 refresh",      3'b001, 12'hFFF, 2'd3);
    cmd("R10 load mode",    3'b000, 12'h033, 2'd0);
    cmd("R7 pre single b1", 3'b010, 12'h000, 2'd1);
    cmd("R4 act b0",        3'b011, 12'h0F0, 2'd0);
    cmd("R4 act b3",        3'b011, 12'hF0F, 2'd3);
    cmd("R7 pre all",       3'b010, 12'h400, 2'd2);
    cmd("R4 act b0 again",  3'b011, 12'h555, 2'd0);
    cmd("R6 rd b0 ap",      3'b101, 12'h400, 2'd0);
    for (int i = 0; i < 5; i++)
      issue("R2 deselect during ap", 1'b1, 1'b1, 3'b010, 12'h400, 2'd0);
    cmd("R8 rd after ap close", 3'b101, 12'h000, 2'd0);
    cmd("R6 act b1",        3'b011, 12'h222, 2'd1);
    cmd("R6 rd b1 no ap",   3'b101, 12'h010, 2'd1);
    repeat (BL + 1) cmd("R6 b1 stays open", 3'b111, 12'h000, 2'd0);
    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule